// File: doc/BRIEF.md
# Floating-Point Issue and Completion Arbiter

This block decides when an instruction waiting in the decode stage may leave for its execution path, and which execution path may write into the single shared memory stage in each cycle. There are four paths: a one-cycle integer execute stage and three floating-point units (add/subtract, multiply, divide). Each floating-point unit is modelled as a shift pipe whose depth is set at run time. The add and multiply pipes take one new instruction per cycle. The divide unit takes one instruction at a time and finishes it before taking another. An instruction that enters a floating-point unit sits in the unit's entry stage until an external scoreboard reports that its operands are ready.

Completion order follows latency, not program order. A short operation issued after a long one may reach the memory stage first. This creates a write-after-read risk: a younger instruction could overwrite a register that an older instruction, still parked in an entry stage, has not yet read. The block detects this case and holds the younger instruction in decode.

When several paths want the memory stage in the same cycle, the longest configured latency wins. A path that is refused freezes in place and takes no new work. Two counters record the cycles lost to memory-stage conflicts and to write-after-read holds.

Top module: `fpa_issue_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, no grant is given and both stall counters read zero.
- R2: With no contention and operands ready, a floating-point instruction issued in cycle c with configured latency L is granted in cycle c+L. An integer instruction is granted in cycle c+1. Grant bit 0 is the integer path, bit 1 add, bit 2 multiply, bit 3 divide, and `mem_dst` carries the granted instruction's destination.
- R3: A younger instruction in a shorter-latency unit is granted before an older instruction in a longer-latency unit.
- R4: When several paths request in one cycle, the grant goes to a requester with the largest latency. The integer path counts as latency 1.
- R5: On equal latency, divide beats multiply, multiply beats add, and add beats the integer path.
- R6: A path refused the memory stage keeps its head and all its stages frozen, is granted later without losing the instruction, and refuses issue while refused.
- R7: The add and multiply units accept one instruction per cycle, so back-to-back issues are granted in consecutive cycles.
- R8: The divide unit accepts nothing from the cycle it takes an instruction until the cycle after that instruction's grant.
- R9: An instruction whose operands are not ready stays in its unit's entry stage. It reaches the head L-1 cycles after its first cycle with operands ready.
- R10: A floating-point instruction whose destination equals a source of an instruction still waiting in any floating-point entry stage is held in decode. Integer instructions are never held for this reason.
- R11: `struct_stalls` rises by one in each cycle with more than one requester. `war_stalls` rises by one in each cycle a valid decode instruction is held by R10.
- R12: At most one grant bit is set in any cycle, and only for a path that is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_unit | input | 2 | Target path: 0 integer, 1 add, 2 multiply, 3 divide |
| id_src_a | input | REG_W | First source register |
| id_src_b | input | REG_W | Second source register |
| id_dst | input | REG_W | Destination register |
| cfg_add_lat | input | LAT_W | Add unit latency in cycles |
| cfg_mul_lat | input | LAT_W | Multiply unit latency in cycles |
| cfg_div_lat | input | LAT_W | Divide unit latency in cycles |
| opnd_rdy | input | 3 | Operands ready for entry stage: bit 0 add, 1 multiply, 2 divide |
| id_issue | output | 1 | Decode instruction leaves this cycle |
| mem_grant | output | 4 | One-hot memory stage grant |
| mem_dst | output | REG_W | Destination of the granted instruction |
| struct_stalls | output | CNT_W | Memory-conflict cycle count |
| war_stalls | output | CNT_W | Write-after-read hold cycle count |

## Verification
The hardest situations to reach are exact ties, because decode issues only one instruction per cycle. Two paths of equal latency therefore never reach the memory stage together on their own. The bench creates ties by lowering one unit's operand-ready input for a cycle. This delays the older instruction in its entry stage until a younger one catches up. The same lever keeps an older add parked with unread sources, which lets the bench offer conflicting and harmless destinations to decode, plus an integer instruction, while the risk is live.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   typedef enum logic [1:0] {
      UNIT_INT = 2'd0,
      UNIT_ADD = 2'd1,
      UNIT_MUL = 2'd2,
      UNIT_DIV = 2'd3
   } unit_e;

   localparam int NUM_UNITS = 4;

   // Tie order equals unit index: a higher index wins at equal latency.
   function automatic bit unit_is_pipelined(input int idx);
      return idx != int'(UNIT_DIV);
   endfunction

   function automatic bit unit_is_fp(input int idx);
      return idx != int'(UNIT_INT);
   endfunction
endpackage

// File: rtl/fpa_unit_pipe.sv
module fpa_unit_pipe #(
   parameter int MAX_LAT   = 8,
   parameter int LAT_W     = 4,
   parameter int ENT_W     = 15,
   parameter int DST_W     = 5,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LAT_W-1:0]       lat_cfg,
   input  logic                   opnd_rdy,
   input  logic                   in_valid,
   input  logic [ENT_W-1:0]       in_ent,
   input  logic                   grant,
   output logic                   accept,
   output logic                   req,
   output logic [DST_W-1:0]       head_dst,
   output logic                   pend,
   output logic [ENT_W-DST_W-1:0] pend_src
);
   localparam int IDX_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

   if (MAX_LAT < 1) begin : g_bad_depth
      $error("fpa_unit_pipe: MAX_LAT must be at least 1");
   end
   if (DST_W >= ENT_W) begin : g_bad_ent
      $error("fpa_unit_pipe: entry must hold more than the destination");
   end

   logic [MAX_LAT-1:0] v_q, v_d;
   logic [ENT_W-1:0]   e_q [MAX_LAT];
   logic [ENT_W-1:0]   e_d [MAX_LAT];
   logic [IDX_W-1:0]   head_idx;
   logic               head_v, first_only, hold, move0, leave0;

   always_comb begin
      if (lat_cfg == '0)
         head_idx = '0;
      else if (int'(lat_cfg) > MAX_LAT)
         head_idx = IDX_W'(MAX_LAT - 1);
      else
         head_idx = IDX_W'(lat_cfg - 1'b1);
   end

   assign head_v     = v_q[head_idx];
   assign head_dst   = e_q[head_idx][ENT_W-1 -: DST_W];
   assign first_only = (head_idx == '0);
   assign req        = head_v && (!first_only || opnd_rdy);
   assign hold       = head_v && !grant;
   assign move0      = v_q[0] && opnd_rdy && !first_only && !hold;
   assign leave0     = move0 || (first_only && grant);
   assign pend       = v_q[0] && !leave0;
   assign pend_src   = e_q[0][ENT_W-DST_W-1:0];

   if (PIPELINED) begin : g_pipe
      assign accept = !hold && (!v_q[0] || leave0);
   end else begin : g_single
      assign accept = !(|v_q);
   end

   always_comb begin
      v_d = v_q;
      e_d = e_q;
      if (!hold) begin
         for (int k = 1; k < MAX_LAT; k++) begin
            if (k <= int'(head_idx)) begin
               v_d[k] = (k == 1) ? move0 : v_q[k-1];
               e_d[k] = e_q[k-1];
            end
         end
      end
      if (leave0) v_d[0] = 1'b0;
      if (in_valid && accept) begin
         v_d[0] = 1'b1;
         e_d[0] = in_ent;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= v_d;
   end

   always_ff @(posedge clk) begin
      e_q <= e_d;
   end
endmodule

// File: rtl/fpa_mem_arb.sv
module fpa_mem_arb #(
   parameter int N     = 4,
   parameter int LAT_W = 4
) (
   input  logic [N-1:0]       req,
   input  logic [N*LAT_W-1:0] lat_flat,
   output logic [N-1:0]       grant
);
   if (N < 2) begin : g_bad_n
      $error("fpa_mem_arb: at least two requesters expected");
   end

   logic [LAT_W-1:0] best;
   logic             found;
   int               sel;

   // Ascending scan with >= lets the higher index take equal latency.
   always_comb begin
      grant = '0;
      best  = '0;
      found = 1'b0;
      sel   = 0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!found || lat_flat[i*LAT_W +: LAT_W] >= best)) begin
            found = 1'b1;
            best  = lat_flat[i*LAT_W +: LAT_W];
            sel   = i;
         end
      end
      if (found) grant[sel] = 1'b1;
   end
endmodule

// File: rtl/fpa_war_detect.sv
module fpa_war_detect #(
   parameter int          N       = 4,
   parameter int          REG_W   = 5,
   parameter logic [N-1:0] FP_MASK = '1
) (
   input  logic                 id_is_fp,
   input  logic [REG_W-1:0]     id_dst,
   input  logic [N-1:0]         pend,
   input  logic [N*2*REG_W-1:0] pend_src,
   output logic                 war_hit
);
   always_comb begin
      war_hit = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (FP_MASK[i] && pend[i] &&
             (pend_src[i*2*REG_W +: REG_W] == id_dst ||
              pend_src[i*2*REG_W + REG_W +: REG_W] == id_dst))
            war_hit = 1'b1;
      end
      war_hit = war_hit && id_is_fp;
   end
endmodule

// File: rtl/fpa_stall_ctr.sv
module fpa_stall_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 1) begin : g_bad_w
      $error("fpa_stall_ctr: CNT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (bump) count <= count + 1'b1;
   end
endmodule

// File: rtl/fpa_issue_arbiter.sv
module fpa_issue_arbiter
   import fpa_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int MAX_LAT = 8,
   parameter int CNT_W   = 16,
   parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_valid,
   input  logic [1:0]       id_unit,
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   input  logic [REG_W-1:0] id_dst,
   input  logic [LAT_W-1:0] cfg_add_lat,
   input  logic [LAT_W-1:0] cfg_mul_lat,
   input  logic [LAT_W-1:0] cfg_div_lat,
   input  logic [2:0]       opnd_rdy,
   output logic             id_issue,
   output logic [3:0]       mem_grant,
   output logic [REG_W-1:0] mem_dst,
   output logic [CNT_W-1:0] struct_stalls,
   output logic [CNT_W-1:0] war_stalls
);
   localparam int ENT_W = 3 * REG_W;
   localparam int SRC_W = 2 * REG_W;
   localparam logic [NUM_UNITS-1:0] FP_MASK = 4'b1110;

   if (REG_W < 1) begin : g_bad_reg
      $error("fpa_issue_arbiter: REG_W must be positive");
   end
   if (LAT_W < $clog2(MAX_LAT + 1)) begin : g_bad_lat
      $error("fpa_issue_arbiter: LAT_W too narrow for MAX_LAT");
   end

   logic [ENT_W-1:0]           ent_in;
   logic [LAT_W-1:0]           lat_arr [NUM_UNITS];
   logic [NUM_UNITS*LAT_W-1:0] lat_flat;
   logic [NUM_UNITS-1:0]       rdy_vec, unit_in, unit_accept, req_vec, pend_vec;
   logic [REG_W-1:0]           head_dst [NUM_UNITS];
   logic [NUM_UNITS*SRC_W-1:0] pend_src;
   logic                       id_is_fp, war_hit, multi_req;

   assign ent_in     = {id_dst, id_src_a, id_src_b};
   assign lat_arr[0] = LAT_W'(1);
   assign lat_arr[1] = cfg_add_lat;
   assign lat_arr[2] = cfg_mul_lat;
   assign lat_arr[3] = cfg_div_lat;
   assign rdy_vec    = {opnd_rdy, 1'b1};
   assign id_is_fp   = (id_unit != UNIT_INT);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam bit PIPE_U = unit_is_pipelined(u);
      localparam int DEPTH  = unit_is_fp(u) ? MAX_LAT : 1;

      assign lat_flat[u*LAT_W +: LAT_W] = lat_arr[u];
      assign unit_in[u] = id_issue && (id_unit == 2'(u));

      fpa_unit_pipe #(
         .MAX_LAT  (DEPTH),
         .LAT_W    (LAT_W),
         .ENT_W    (ENT_W),
         .DST_W    (REG_W),
         .PIPELINED(PIPE_U)
      ) u_pipe (
         .clk     (clk),
         .rst_n   (rst_n),
         .lat_cfg (lat_arr[u]),
         .opnd_rdy(rdy_vec[u]),
         .in_valid(unit_in[u]),
         .in_ent  (ent_in),
         .grant   (mem_grant[u]),
         .accept  (unit_accept[u]),
         .req     (req_vec[u]),
         .head_dst(head_dst[u]),
         .pend    (pend_vec[u]),
         .pend_src(pend_src[u*SRC_W +: SRC_W])
      );
   end

   fpa_mem_arb #(
      .N    (NUM_UNITS),
      .LAT_W(LAT_W)
   ) u_arb (
      .req     (req_vec),
      .lat_flat(lat_flat),
      .grant   (mem_grant)
   );

   fpa_war_detect #(
      .N      (NUM_UNITS),
      .REG_W  (REG_W),
      .FP_MASK(FP_MASK)
   ) u_war (
      .id_is_fp(id_is_fp),
      .id_dst  (id_dst),
      .pend    (pend_vec),
      .pend_src(pend_src),
      .war_hit (war_hit)
   );

   assign id_issue = id_valid && unit_accept[id_unit] && !war_hit;

   always_comb begin
      mem_dst = '0;
      for (int u = 0; u < NUM_UNITS; u++)
         if (mem_grant[u]) mem_dst = head_dst[u];
   end

   always_comb begin
      int n;
      n = 0;
      for (int u = 0; u < NUM_UNITS; u++)
         if (req_vec[u]) n++;
      multi_req = (n > 1);
   end

   fpa_stall_ctr #(.CNT_W(CNT_W)) u_struct_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (multi_req),
      .count(struct_stalls)
   );

   fpa_stall_ctr #(.CNT_W(CNT_W)) u_war_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (id_valid && war_hit),
      .count(war_stalls)
   );
endmodule

// File: rtl/fpa_issue_arbiter_chk.sv
module fpa_issue_arbiter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mem_grant,
   input logic [3:0]       req_vec,
   input logic [3:0]       unit_accept,
   input logic             war_hit,
   input logic             id_issue,
   input logic [CNT_W-1:0] struct_stalls,
   input logic [CNT_W-1:0] war_stalls
);
   // R12
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_grant));

   // R12
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_grant & ~req_vec) == 4'b0000);

   // R10
   war_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      war_hit |-> !id_issue);

   // R8
   div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_grant[3] |-> !unit_accept[3]);

   // R6
   deny_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec[2] && !mem_grant[2]) |-> !unit_accept[2]);

   // R11
   struct_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (struct_stalls == $past(struct_stalls) ||
                struct_stalls == CNT_W'($past(struct_stalls) + 1'b1)));

   // R11
   war_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (war_stalls == $past(war_stalls) ||
                war_stalls == CNT_W'($past(war_stalls) + 1'b1)));
endmodule

bind fpa_issue_arbiter fpa_issue_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_grant    (mem_grant),
   .req_vec      (req_vec),
   .unit_accept  (unit_accept),
   .war_hit      (war_hit),
   .id_issue     (id_issue),
   .struct_stalls(struct_stalls),
   .war_stalls   (war_stalls)
);

// File: tb/tb_fpa_issue_arbiter.sv
`timescale 1ns/1ps
module tb_fpa_issue_arbiter;
   localparam logic [1:0] U_INT = 2'd0, U_ADD = 2'd1, U_MUL = 2'd2, U_DIV = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        id_valid = 1'b0;
   logic [1:0]  id_unit = '0;
   logic [4:0]  id_src_a = '0, id_src_b = '0, id_dst = '0;
   logic [3:0]  cfg_add_lat = 4'd2, cfg_mul_lat = 4'd4, cfg_div_lat = 4'd6;
   logic [2:0]  opnd_rdy = 3'b111;
   logic        id_issue;
   logic [3:0]  mem_grant;
   logic [4:0]  mem_dst;
   logic [15:0] struct_stalls, war_stalls;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fpa_issue_arbiter dut (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
      .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
      .cfg_add_lat(cfg_add_lat), .cfg_mul_lat(cfg_mul_lat), .cfg_div_lat(cfg_div_lat),
      .opnd_rdy(opnd_rdy), .id_issue(id_issue), .mem_grant(mem_grant),
      .mem_dst(mem_dst), .struct_stalls(struct_stalls), .war_stalls(war_stalls)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Next cycle: inputs are driven 2 ns after the rising edge.
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic look();
      #1;
   endtask

   task automatic put(input logic [1:0] u, input logic [4:0] d,
                      input logic [4:0] a, input logic [4:0] b);
      id_valid = 1'b1; id_unit = u; id_dst = d; id_src_a = a; id_src_b = b;
   endtask

   task automatic idle();
      id_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; id_valid = 1'b0; opnd_rdy = 3'b111;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; id_valid = 1'b0;
      repeat (2) @(posedge clk);
      #2; look();
      check("R1 grant in reset", 32'(mem_grant), 32'h0);
      check("R1 struct count in reset", 32'(struct_stalls), 32'h0);
      check("R1 war count in reset", 32'(war_stalls), 32'h0);
      rst_n = 1'b1;
      tick(); look();
      check("R1 grant after reset", 32'(mem_grant), 32'h0);
   endtask

   task automatic t_latency();
      cfg_add_lat = 4'd3; cfg_mul_lat = 4'd5;
      do_reset();
      put(U_ADD, 5'd2, 5'd0, 5'd1); look();
      check("R2 add issues", 32'(id_issue), 32'h1);
      for (int i = 1; i < 3; i++) begin
         tick(); idle(); look();
         check("R2 add not early", 32'(mem_grant), 32'h0);
      end
      tick(); look();
      check("R2 add grant at c+3", 32'(mem_grant), 32'h2);
      check("R2 add dst", 32'(mem_dst), 32'd2);
      put(U_INT, 5'd9, 5'd1, 5'd1);
      tick(); idle(); look();
      check("R2 int grant at c+1", 32'(mem_grant), 32'h1);
      check("R2 int dst", 32'(mem_dst), 32'd9);
      put(U_MUL, 5'd11, 5'd1, 5'd2);
      for (int i = 1; i < 5; i++) begin
         tick(); idle(); look();
         check("R2 mul not early", 32'(mem_grant), 32'h0);
      end
      tick(); look();
      check("R2 mul grant at c+5", 32'(mem_grant), 32'h4);
   endtask

   task automatic t_out_of_order();
      cfg_add_lat = 4'd2; cfg_div_lat = 4'd6;
      do_reset();
      put(U_DIV, 5'd4, 5'd1, 5'd2);
      tick(); put(U_ADD, 5'd5, 5'd1, 5'd2); look();
      check("R3 add issues behind div", 32'(id_issue), 32'h1);
      tick(); idle();
      tick(); look();
      check("R3 younger add first", 32'(mem_grant), 32'h2);
      check("R3 younger add dst", 32'(mem_dst), 32'd5);
      repeat (3) tick();
      look();
      check("R3 older div later", 32'(mem_grant), 32'h8);
      check("R3 div dst", 32'(mem_dst), 32'd4);
   endtask

   task automatic t_longest();
      cfg_add_lat = 4'd2; cfg_mul_lat = 4'd4;
      do_reset();
      put(U_MUL, 5'd1, 5'd10, 5'd11);
      tick(); idle();
      tick(); put(U_ADD, 5'd2, 5'd10, 5'd11);
      tick(); idle();
      tick(); put(U_ADD, 5'd3, 5'd12, 5'd13); look();
      check("R4 mul wins conflict", 32'(mem_grant), 32'h4);
      check("R4 winner dst", 32'(mem_dst), 32'd1);
      check("R6 denied add refuses issue", 32'(id_issue), 32'h0);
      tick(); look();
      check("R6 frozen add granted next", 32'(mem_grant), 32'h2);
      check("R6 frozen add dst kept", 32'(mem_dst), 32'd2);
      check("R6 add accepts once granted", 32'(id_issue), 32'h1);
      tick(); idle(); look();
      check("R11 one structural stall", 32'(struct_stalls), 32'd1);
      tick(); look();
      check("R6 later add dst", 32'(mem_dst), 32'd3);
   endtask

   task automatic t_tie();
      cfg_add_lat = 4'd3; cfg_mul_lat = 4'd3;
      do_reset();
      put(U_MUL, 5'd6, 5'd1, 5'd2);
      tick(); opnd_rdy = 3'b101; put(U_ADD, 5'd7, 5'd1, 5'd2);
      tick(); opnd_rdy = 3'b111; idle();
      tick();
      tick(); look();
      check("R5 mul beats add on tie", 32'(mem_grant), 32'h4);
      check("R5 mul dst", 32'(mem_dst), 32'd6);
      tick(); look();
      check("R5 add after mul", 32'(mem_grant), 32'h2);
      cfg_add_lat = 4'd1;
      tick(); put(U_ADD, 5'd8, 5'd1, 5'd2);
      tick(); opnd_rdy = 3'b110; put(U_INT, 5'd9, 5'd1, 5'd2);
      tick(); opnd_rdy = 3'b111; idle(); look();
      check("R5 add beats int on tie", 32'(mem_grant), 32'h2);
      check("R5 add dst", 32'(mem_dst), 32'd8);
      tick(); look();
      check("R5 int after add", 32'(mem_grant), 32'h1);
      check("R11 two structural stalls", 32'(struct_stalls), 32'd2);
   endtask

   task automatic t_pipelined();
      cfg_add_lat = 4'd2;
      do_reset();
      put(U_ADD, 5'd10, 5'd1, 5'd2); look();
      check("R7 first add issues", 32'(id_issue), 32'h1);
      tick(); put(U_ADD, 5'd11, 5'd1, 5'd2); look();
      check("R7 second add issues", 32'(id_issue), 32'h1);
      tick(); put(U_ADD, 5'd12, 5'd1, 5'd2); look();
      check("R7 third add issues", 32'(id_issue), 32'h1);
      check("R7 first grant dst", 32'(mem_dst), 32'd10);
      tick(); idle(); look();
      check("R7 second grant dst", 32'(mem_dst), 32'd11);
      tick(); look();
      check("R7 third grant dst", 32'(mem_dst), 32'd12);
      check("R7 third grant bit", 32'(mem_grant), 32'h2);
   endtask

   task automatic t_divide();
      cfg_div_lat = 4'd2;
      do_reset();
      put(U_DIV, 5'd13, 5'd1, 5'd2); look();
      check("R8 div issues", 32'(id_issue), 32'h1);
      tick(); put(U_DIV, 5'd14, 5'd1, 5'd2); look();
      check("R8 div busy", 32'(id_issue), 32'h0);
      tick(); look();
      check("R8 div grant", 32'(mem_grant), 32'h8);
      check("R8 busy in grant cycle", 32'(id_issue), 32'h0);
      tick(); look();
      check("R8 div free after grant", 32'(id_issue), 32'h1);
      tick(); idle();
      tick(); look();
      check("R8 second div dst", 32'(mem_dst), 32'd14);
   endtask

   task automatic t_operands();
      cfg_mul_lat = 4'd2;
      do_reset();
      put(U_MUL, 5'd15, 5'd1, 5'd2);
      tick(); idle(); opnd_rdy = 3'b101; look();
      check("R9 waiting no grant", 32'(mem_grant), 32'h0);
      tick(); look();
      check("R9 still waiting", 32'(mem_grant), 32'h0);
      tick(); opnd_rdy = 3'b111; look();
      check("R9 not at head yet", 32'(mem_grant), 32'h0);
      tick(); look();
      check("R9 grant after ready", 32'(mem_grant), 32'h4);
   endtask

   task automatic t_war();
      cfg_add_lat = 4'd2; cfg_mul_lat = 4'd2;
      do_reset();
      put(U_ADD, 5'd7, 5'd7, 5'd3);
      tick(); opnd_rdy = 3'b110; put(U_MUL, 5'd3, 5'd5, 5'd6); look();
      check("R10 conflicting mul held", 32'(id_issue), 32'h0);
      tick(); look();
      check("R10 mul still held", 32'(id_issue), 32'h0);
      tick(); put(U_INT, 5'd3, 5'd5, 5'd6); look();
      check("R10 int not held", 32'(id_issue), 32'h1);
      check("R11 two war stalls", 32'(war_stalls), 32'd2);
      tick(); put(U_MUL, 5'd9, 5'd1, 5'd2); look();
      check("R10 harmless mul issues", 32'(id_issue), 32'h1);
      tick(); opnd_rdy = 3'b111; put(U_MUL, 5'd3, 5'd5, 5'd6); look();
      check("R10 released when add reads", 32'(id_issue), 32'h1);
      tick(); idle(); look();
      check("R11 war count settles", 32'(war_stalls), 32'd2);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_out_of_order();
      t_longest();
      t_tie();
      t_pipelined();
      t_divide();
      t_operands();
      t_war();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule